// File: doc/BRIEF.md
# Firmware Table Signature Scanner

This block searches a window of byte-addressable memory for a 10-character ASCII marker, as firmware leaves behind to publish processor performance tables. When the scan starts, the block latches a processor identifier, a maximum frequency code and a maximum voltage code. It then reads memory one byte at a time through a synchronous read port and tests only addresses on a 16-byte grid. When the marker matches, it reads the header that follows it. If the version byte is wrong, the search stops at once. Otherwise it decodes the settling time and the packed timing-parameter byte, then walks the table records that follow the header.

Each record holds an identifier, a PLL lock byte, a frequency code, a voltage code and a state count, followed by that many two-byte frequency/voltage pairs. The scanner steps over a record that does not match by using its embedded count. On the record whose three keys all match, it reports the lock byte, the state count and the pairs. A header with no matching record sends the scan back to the next grid address after that marker. If the window runs out, the block reports not-found.

Top module: `fwtbl_scan`

## Requirements
- R1: A `start` pulse while idle raises `busy` on the next cycle and latches `cpu_id`, `want_fid` and `want_vid`. A `start` pulse or a change to those inputs while `busy` is high has no effect on the result.
- R2: Each read is a single-cycle `mem_rd` pulse, and `mem_rdata` carries the byte in the cycle after it. `mem_rd` is never high in two consecutive cycles, and it is high only while `busy`.
- R3: Candidate addresses are BASE + 16·k, starting at BASE = 0xE0000, for all candidates below BASE + 0x20000. The first read after start is at 0xE0000, and a marker at an address that is not a multiple of 16 is never detected.
- R4: A marker is the 10 bytes "PSTATETBL!", with the first character at the lowest address. A mismatch in any of its bytes abandons that candidate and moves the scan to the next one.
- R5: The byte at offset 10 from the marker must equal 0x14. Any other value ends the scan with `ver_err` = 1, `found` = 0 and `n_states` = 0.
- R6: `vst` is the little-endian 16-bit value at offsets 12–13. The byte at offset 14 is unpacked into `rvo` (bits 1:0), `irt` (bits 3:2), `mvs` (bits 5:4) and `batt` (bits 7:6). Offset 15 gives the number of records, and the first record starts at offset 16.
- R7: A record is 8 bytes long, laid out as follows:
  - offsets 0–3: identifier, little-endian;
  - offset 4: lock byte;
  - offset 5: frequency code;
  - offset 6: voltage code;
  - offset 7: state count.

  The scanner selects a record only when the identifier, frequency code and voltage code all equal the latched inputs. It then sets `found`, `tbl_pll` and `n_states`. Pair i goes to `pairs[16i+7:16i]` (frequency byte, read first) and `pairs[16i+15:16i+8]` (voltage byte).
- R8: A record that does not match, including one that matches on the identifier alone, is skipped by 8 + 2·count bytes to the next record.
- R9: A header whose records all fail to match, or which has a record count of zero, sends the scan on to the next candidate after that marker. When no candidate is left, the block sets `not_found` = 1, `n_states` = 0 and `pairs` = 0.
- R10: `found`, `not_found` and `ver_err` are mutually exclusive. At most one is set when `busy` falls, and all results hold unchanged until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan (accepted only while idle) |
| cpu_id | input | 32 | Processor identifier to match |
| want_fid | input | 8 | Maximum frequency code to match |
| want_vid | input | 8 | Maximum voltage code to match |
| mem_rd | output | 1 | Read strobe to the memory port |
| mem_addr | output | ADDR_W | Byte address of the read |
| mem_rdata | input | 8 | Read data, valid the cycle after `mem_rd` |
| busy | output | 1 | Scan in progress |
| found | output | 1 | A matching record was selected |
| not_found | output | 1 | Window exhausted without a match |
| ver_err | output | 1 | Marker found with a wrong version byte |
| vst | output | 16 | Settling time from the last parsed header |
| rvo | output | 2 | Voltage offset field from the packed byte |
| irt | output | 2 | Isochronous relief field from the packed byte |
| mvs | output | 2 | Voltage step field from the packed byte |
| batt | output | 2 | Battery field from the packed byte |
| tbl_pll | output | 8 | Lock byte of the selected record |
| n_states | output | 8 | State count of the selected record (0 if none) |
| pairs | output | 16·MAX_ST | Frequency/voltage pairs of the selected record |

## Verification
A corrupted byte index or address pointer shows at the ports within one record, and usually within one byte. Such an error makes the scanner read the wrong next address, take a wrong lock byte or count, or misplace pairs. The bench catches this through the final `tbl_pll`, `n_states` and `pairs` values. A broken skip distance or resume path shows up as a wrong selected table or a false `not_found` once the scan ends. A corrupted handshake phase shows up at once as back-to-back read strobes.

// File: rtl/fwtbl_pkg.sv
package fwtbl_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_SIG,
        S_HDR,
        S_REC,
        S_PAIR
    } scan_st_t;

    localparam int SIG_BYTES = 10;
    localparam int HDR_BYTES = 16;
    localparam int REC_BYTES = 8;
endpackage

// File: rtl/fwtbl_sig_rom.sv
module fwtbl_sig_rom #(
    parameter logic [79:0] SIG = "PSTATETBL!"
) (
    input  logic [3:0] idx,
    output logic [7:0] ch
);
    always_comb begin
        ch = 8'h00;
        for (int k = 0; k < fwtbl_pkg::SIG_BYTES; k++) begin
            if (idx == 4'(k)) begin
                ch = SIG[8*(9-k) +: 8];
            end
        end
    end
endmodule

// File: rtl/fwtbl_pair_store.sv
module fwtbl_pair_store #(
    parameter int MAX_ST = 16,
    parameter int IDX_W  = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clr,
    input  logic                  we,
    input  logic [IDX_W-1:0]      widx,
    input  logic [7:0]            wdata,
    output logic [16*MAX_ST-1:0]  pairs
);
    localparam int NBYTES = 2 * MAX_ST;

    for (genvar i = 0; i < NBYTES; i++) begin : g_byte
        logic [7:0] byte_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= 8'h00;
            end else if (clr) begin
                byte_q <= 8'h00;
            end else if (we && widx == IDX_W'(i)) begin
                byte_q <= wdata;
            end
        end
        assign pairs[8*i +: 8] = byte_q;
    end
endmodule

// File: rtl/fwtbl_scan.sv
module fwtbl_scan #(
    parameter int          ADDR_W    = 24,
    parameter int          BASE_ADDR = 'hE0000,
    parameter int          WIN_LEN   = 'h20000,
    parameter int          STRIDE    = 16,
    parameter int          MAX_ST    = 16,
    parameter logic [7:0]  VERSION   = 8'h14,
    parameter logic [79:0] SIG       = "PSTATETBL!"
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [31:0]           cpu_id,
    input  logic [7:0]            want_fid,
    input  logic [7:0]            want_vid,
    output logic                  mem_rd,
    output logic [ADDR_W-1:0]     mem_addr,
    input  logic [7:0]            mem_rdata,
    output logic                  busy,
    output logic                  found,
    output logic                  not_found,
    output logic                  ver_err,
    output logic [15:0]           vst,
    output logic [1:0]            rvo,
    output logic [1:0]            irt,
    output logic [1:0]            mvs,
    output logic [1:0]            batt,
    output logic [7:0]            tbl_pll,
    output logic [7:0]            n_states,
    output logic [16*MAX_ST-1:0]  pairs
);
    import fwtbl_pkg::*;

    localparam int IDX_W = 9;
    localparam logic [ADDR_W-1:0] BASE_A   = ADDR_W'(BASE_ADDR);
    localparam logic [ADDR_W-1:0] LIMIT_A  = ADDR_W'(BASE_ADDR + WIN_LEN);
    localparam logic [ADDR_W-1:0] STRIDE_A = ADDR_W'(STRIDE);
    localparam logic [ADDR_W-1:0] ONE_A    = ADDR_W'(1);

    typedef struct packed {
        scan_st_t          st;
        logic              rdy;
        logic [IDX_W-1:0]  idx;
        logic [ADDR_W-1:0] addr;
        logic [ADDR_W-1:0] cand;
        logic [7:0]        tbl_left;
        logic              match;
        logic [7:0]        rec_pll;
        logic [7:0]        rec_cnt;
        logic [31:0]       id;
        logic [7:0]        fid;
        logic [7:0]        vid;
        logic              found;
        logic              nf;
        logic              verr;
        logic [15:0]       vst;
        logic [7:0]        pk;
        logic [7:0]        pll;
        logic [7:0]        nst;
    } regs_t;

    regs_t q, d;

    logic             pw_en;
    logic             pw_clr;
    logic [7:0]       sig_ch;
    logic             resume;
    logic [ADDR_W-1:0] nxt_cand;
    logic [ADDR_W-1:0] skip_len;

    fwtbl_sig_rom #(.SIG(SIG)) u_sig (
        .idx (q.idx[3:0]),
        .ch  (sig_ch)
    );

    fwtbl_pair_store #(.MAX_ST(MAX_ST), .IDX_W(IDX_W)) u_pairs (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pw_clr),
        .we    (pw_en),
        .widx  (q.idx),
        .wdata (mem_rdata),
        .pairs (pairs)
    );

    assign nxt_cand = q.cand + STRIDE_A;
    assign skip_len = ADDR_W'({mem_rdata, 1'b0}) + ONE_A;

    always_comb begin
        d      = q;
        pw_en  = 1'b0;
        pw_clr = 1'b0;
        resume = 1'b0;
        if (q.st == S_IDLE) begin
            if (start) begin
                d.st    = S_SIG;
                d.rdy   = 1'b0;
                d.idx   = '0;
                d.addr  = BASE_A;
                d.cand  = BASE_A;
                d.id    = cpu_id;
                d.fid   = want_fid;
                d.vid   = want_vid;
                d.found = 1'b0;
                d.nf    = 1'b0;
                d.verr  = 1'b0;
                d.vst   = '0;
                d.pk    = '0;
                d.pll   = '0;
                d.nst   = '0;
                pw_clr  = 1'b1;
            end
        end else if (!q.rdy) begin
            d.rdy = 1'b1;
        end else begin
            d.rdy  = 1'b0;
            d.addr = q.addr + ONE_A;
            d.idx  = q.idx + IDX_W'(1);
            case (q.st)
                S_SIG: begin
                    if (mem_rdata != sig_ch) begin
                        resume = 1'b1;
                    end else if (q.idx == IDX_W'(SIG_BYTES - 1)) begin
                        d.st = S_HDR;
                    end
                end
                S_HDR: begin
                    case (q.idx)
                        IDX_W'(10): begin
                            if (mem_rdata != VERSION) begin
                                d.st   = S_IDLE;
                                d.verr = 1'b1;
                            end
                        end
                        IDX_W'(12): d.vst[7:0]  = mem_rdata;
                        IDX_W'(13): d.vst[15:8] = mem_rdata;
                        IDX_W'(14): d.pk        = mem_rdata;
                        IDX_W'(15): begin
                            if (mem_rdata == 8'h00) begin
                                resume = 1'b1;
                            end else begin
                                d.tbl_left = mem_rdata;
                                d.st       = S_REC;
                                d.idx      = '0;
                                d.match    = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
                S_REC: begin
                    case (q.idx)
                        IDX_W'(0), IDX_W'(1), IDX_W'(2), IDX_W'(3):
                            d.match = q.match &&
                                (mem_rdata == q.id[{q.idx[1:0], 3'b000} +: 8]);
                        IDX_W'(4): d.rec_pll = mem_rdata;
                        IDX_W'(5): d.match = q.match && (mem_rdata == q.fid);
                        IDX_W'(6): d.match = q.match && (mem_rdata == q.vid);
                        default: begin
                            d.rec_cnt = mem_rdata;
                            if (q.match) begin
                                d.pll = q.rec_pll;
                                d.nst = mem_rdata;
                                d.idx = '0;
                                if (mem_rdata == 8'h00) begin
                                    d.st    = S_IDLE;
                                    d.found = 1'b1;
                                end else begin
                                    d.st = S_PAIR;
                                end
                            end else if (q.tbl_left == 8'd1) begin
                                resume = 1'b1;
                            end else begin
                                d.addr     = q.addr + skip_len;
                                d.tbl_left = q.tbl_left - 8'd1;
                                d.idx      = '0;
                                d.match    = 1'b1;
                            end
                        end
                    endcase
                end
                S_PAIR: begin
                    pw_en = 1'b1;
                    if (q.idx == {q.rec_cnt, 1'b0} - IDX_W'(1)) begin
                        d.st    = S_IDLE;
                        d.found = 1'b1;
                    end
                end
                default: d.st = S_IDLE;
            endcase
            if (resume) begin
                if (nxt_cand >= LIMIT_A) begin
                    d.st  = S_IDLE;
                    d.nf  = 1'b1;
                end else begin
                    d.st   = S_SIG;
                    d.addr = nxt_cand;
                    d.cand = nxt_cand;
                    d.idx  = '0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: S_IDLE, default: '0};
        end else begin
            q <= d;
        end
    end

    assign busy      = (q.st != S_IDLE);
    assign mem_rd    = busy && !q.rdy;
    assign mem_addr  = q.addr;
    assign found     = q.found;
    assign not_found = q.nf;
    assign ver_err   = q.verr;
    assign vst       = q.vst;
    assign rvo       = q.pk[1:0];
    assign irt       = q.pk[3:2];
    assign mvs       = q.pk[5:4];
    assign batt      = q.pk[7:6];
    assign tbl_pll   = q.pll;
    assign n_states  = q.nst;
endmodule

// File: rtl/fwtbl_chk.sv
module fwtbl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       start,
    input logic       busy,
    input logic       mem_rd,
    input logic       found,
    input logic       not_found,
    input logic       ver_err,
    input logic [7:0] n_states
);
    assert_start_busy_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    assert_rd_in_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> busy);

    assert_no_back_to_back_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |=> !mem_rd);

    assert_ver_err_empty_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ver_err |-> (n_states == 8'd0));

    assert_nf_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        not_found |-> (n_states == 8'd0));

    assert_flags_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({found, not_found, ver_err}));

    assert_flags_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (found || not_found || ver_err) |-> !busy);

    assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !start) |=> $stable({found, not_found, ver_err, n_states}));
endmodule

bind fwtbl_scan fwtbl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .busy      (busy),
    .mem_rd    (mem_rd),
    .found     (found),
    .not_found (not_found),
    .ver_err   (ver_err),
    .n_states  (n_states)
);

// File: tb/tb_fwtbl_scan.sv
`timescale 1ns/1ps
module tb_fwtbl_scan;
    localparam int ADDR_W = 24;
    localparam int MAX_ST = 16;
    localparam logic [79:0] TSIG = "PSTATETBL!";

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [31:0] cpu_id = '0;
    logic [7:0] want_fid = '0;
    logic [7:0] want_vid = '0;
    logic mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0] mem_rdata = 8'h00;
    logic busy, found, not_found, ver_err;
    logic [15:0] vst;
    logic [1:0] rvo, irt, mvs, batt;
    logic [7:0] tbl_pll, n_states;
    logic [16*MAX_ST-1:0] pairs;

    int checks = 0;
    int errors = 0;
    logic [7:0] mem [int];
    logic seen_first = 1'b0;
    logic [ADDR_W-1:0] first_addr = '0;
    logic prev_rd = 1'b0;
    int b2b = 0;

    always #2.5 clk = ~clk;

    fwtbl_scan dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cpu_id(cpu_id),
        .want_fid(want_fid), .want_vid(want_vid), .mem_rd(mem_rd),
        .mem_addr(mem_addr), .mem_rdata(mem_rdata), .busy(busy),
        .found(found), .not_found(not_found), .ver_err(ver_err),
        .vst(vst), .rvo(rvo), .irt(irt), .mvs(mvs), .batt(batt),
        .tbl_pll(tbl_pll), .n_states(n_states), .pairs(pairs)
    );

    always @(posedge clk) begin
        if (mem_rd) begin
            mem_rdata <= mem.exists(int'(mem_addr)) ? mem[int'(mem_addr)] : 8'h00;
        end
    end

    always @(negedge clk) begin
        if (mem_rd && !seen_first) begin
            seen_first = 1'b1;
            first_addr = mem_addr;
        end
        if (mem_rd && prev_rd) b2b++;
        prev_rd = mem_rd;
    end

    task automatic chk(input string tag, input logic [255:0] act, input logic [255:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic put_hdr(input int a, input logic [7:0] ver, input logic [15:0] tt,
                           input logic [7:0] pk, input logic [7:0] n);
        for (int i = 0; i < 10; i++) mem[a+i] = TSIG[8*(9-i) +: 8];
        mem[a+10] = ver;
        mem[a+11] = 8'h00;
        mem[a+12] = tt[7:0];
        mem[a+13] = tt[15:8];
        mem[a+14] = pk;
        mem[a+15] = n;
    endtask

    task automatic put_rec(inout int a, input logic [31:0] id, input logic [7:0] pll,
                           input logic [7:0] fid, input logic [7:0] vid,
                           input logic [7:0] cnt, input logic [7:0] seed);
        for (int i = 0; i < 4; i++) mem[a+i] = id[8*i +: 8];
        mem[a+4] = pll;
        mem[a+5] = fid;
        mem[a+6] = vid;
        mem[a+7] = cnt;
        for (int i = 0; i < int'(cnt); i++) begin
            mem[a+8+2*i] = seed + 8'(i);
            mem[a+9+2*i] = seed + 8'h40 + 8'(i);
        end
        a = a + 8 + 2 * int'(cnt);
    endtask

    function automatic logic [255:0] exp_pairs(input int cnt, input logic [7:0] seed);
        logic [255:0] v = '0;
        for (int i = 0; i < cnt; i++) begin
            v[16*i +: 8]     = seed + 8'(i);
            v[16*i + 8 +: 8] = seed + 8'h40 + 8'(i);
        end
        return v;
    endfunction

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        seen_first = 1'b0;
        b2b = 0;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int n = 0;
        while (busy && n < 100000) begin
            @(negedge clk);
            n++;
        end
        if (n >= 100000) chk("watchdog busy", 1, 0);
        @(negedge clk);
    endtask

    task automatic set_keys(input logic [31:0] id, input logic [7:0] f, input logic [7:0] v);
        cpu_id = id; want_fid = f; want_vid = v;
    endtask

    task automatic t_reset();
        chk("R10 reset busy", busy, 0);
        chk("R10 reset flags", {found, not_found, ver_err}, 0);
        chk("R9 reset n_states", n_states, 0);
        chk("R2 reset mem_rd", mem_rd, 0);
    endtask

    task automatic t_basic();
        int a;
        mem.delete();
        put_hdr('hE0100, 8'h14, 16'h1234, 8'h9C, 8'd3);
        a = 'hE0110;
        put_rec(a, 32'hCAFE0001, 8'h21, 8'h0C, 8'h08, 8'd2, 8'h70);
        put_rec(a, 32'h00020F42, 8'h22, 8'h0E, 8'h08, 8'd1, 8'h60);
        put_rec(a, 32'h00020F42, 8'h55, 8'h0C, 8'h08, 8'd3, 8'h08);
        set_keys(32'h00020F42, 8'h0C, 8'h08);
        pulse_start();
        chk("R1 busy after start", busy, 1);
        wait_done();
        chk("R3 first read address", first_addr, 'hE0000);
        chk("R2 back-to-back reads", b2b, 0);
        chk("R7 found", {found, not_found, ver_err}, 3'b100);
        chk("R6 vst", vst, 16'h1234);
        chk("R6 packed fields", {batt, mvs, irt, rvo}, 8'h9C);
        chk("R6 rvo", rvo, 0);
        chk("R6 irt", irt, 3);
        chk("R8 pll of third record", tbl_pll, 8'h55);
        chk("R7 n_states", n_states, 3);
        chk("R7 pairs", pairs, exp_pairs(3, 8'h08));
    endtask

    task automatic t_version();
        int a;
        mem.delete();
        put_hdr('hE0200, 8'h13, 16'h0001, 8'h00, 8'd1);
        a = 'hE0210;
        put_rec(a, 32'h11, 8'h44, 8'h02, 8'h03, 8'd1, 8'h10);
        put_hdr('hE0300, 8'h14, 16'h0001, 8'h00, 8'd1);
        a = 'hE0310;
        put_rec(a, 32'h11, 8'h45, 8'h02, 8'h03, 8'd1, 8'h10);
        set_keys(32'h11, 8'h02, 8'h03);
        pulse_start();
        wait_done();
        chk("R5 ver_err only", {found, not_found, ver_err}, 3'b001);
        chk("R5 n_states zero", n_states, 0);
        chk("R5 pll untouched", tbl_pll, 0);
    endtask

    task automatic t_align();
        int a;
        mem.delete();
        put_hdr('hE0008, 8'h14, 16'h0002, 8'h00, 8'd1);
        a = 'hE0018;
        put_rec(a, 32'h77, 8'h11, 8'h04, 8'h05, 8'd1, 8'h30);
        for (int i = 0; i < 9; i++) mem['hE0040+i] = TSIG[8*(9-i) +: 8];
        mem['hE0049] = "X";
        put_hdr('hE0400, 8'h14, 16'h0003, 8'h00, 8'd1);
        a = 'hE0410;
        put_rec(a, 32'h77, 8'h77, 8'h04, 8'h05, 8'd2, 8'h50);
        set_keys(32'h77, 8'h04, 8'h05);
        pulse_start();
        wait_done();
        chk("R3 R4 found aligned one", found, 1);
        chk("R3 misaligned marker ignored", tbl_pll, 8'h77);
        chk("R4 partial marker skipped vst", vst, 16'h0003);
        chk("R7 pairs aligned", pairs, exp_pairs(2, 8'h50));
    endtask

    task automatic t_resume();
        int a;
        mem.delete();
        put_hdr('hE0010, 8'h14, 16'h00AA, 8'h00, 8'd1);
        a = 'hE0020;
        put_rec(a, 32'h99, 8'h01, 8'h06, 8'h07, 8'd2, 8'h20);
        put_hdr('hE0030, 8'h14, 16'h00BB, 8'h00, 8'd0);
        put_hdr('hE0050, 8'h14, 16'h00CC, 8'h1B, 8'd1);
        a = 'hE0060;
        put_rec(a, 32'h98, 8'h99, 8'h06, 8'h07, 8'd1, 8'h2A);
        set_keys(32'h98, 8'h06, 8'h07);
        pulse_start();
        wait_done();
        chk("R9 resumed to later header", found, 1);
        chk("R9 pll of later header", tbl_pll, 8'h99);
        chk("R9 vst of later header", vst, 16'h00CC);
        chk("R6 mvs", mvs, 1);
        chk("R9 n_states", n_states, 1);
    endtask

    task automatic t_busy_start();
        int a;
        mem.delete();
        put_hdr('hE0100, 8'h14, 16'h0005, 8'h00, 8'd2);
        a = 'hE0110;
        put_rec(a, 32'hB, 8'h66, 8'h01, 8'h01, 8'd1, 8'h05);
        put_rec(a, 32'hA, 8'h33, 8'h01, 8'h01, 8'd1, 8'h01);
        set_keys(32'hA, 8'h01, 8'h01);
        pulse_start();
        repeat (5) @(negedge clk);
        set_keys(32'hB, 8'h01, 8'h01);
        pulse_start();
        chk("R1 still busy after ignored start", busy, 1);
        wait_done();
        chk("R1 latched keys used", tbl_pll, 8'h33);
        chk("R1 found", found, 1);
    endtask

    task automatic t_notfound();
        mem.delete();
        set_keys(32'h1, 8'h1, 8'h1);
        pulse_start();
        wait_done();
        chk("R9 not_found only", {found, not_found, ver_err}, 3'b010);
        chk("R9 n_states cleared", n_states, 0);
        chk("R9 pairs cleared", pairs, 0);
        repeat (5) @(negedge clk);
        chk("R10 result held", {not_found, busy}, 2'b10);
    endtask

    initial begin
        #950000;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_version();
        t_align();
        t_resume();
        t_busy_start();
        t_notfound();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule